// File: doc/BRIEF.md
# Switching Clock Generator with Sync Master/Slave

This block produces the per-cycle start pulse that paces a switching power stage. The cycle length comes from a small frequency code. As master, it drives a shared sync line. The line is high for the first 45% of every cycle, so its rising edge marks each cycle start. As slave, it listens to the sync line, measures every period and every pulse width, and takes its cycle starts from the external edges only after a run of clean periods.

Once locked, each incoming period is compared against the block's own oscillator period. A period outside a ±20% window sends the block back to its own oscillator. So does a sync line that goes quiet. It stays there until slave operation is withdrawn. A phase-select input chooses whether a slave cycle starts a fixed lag after the sync rising edge or after the falling edge, which lets two converters run in phase or in antiphase.

The state is reported as a two-bit mode: 00 master, 01 qualify, 10 locked, 11 fallback. The transitions are:
- GO_SLAVE: master to qualify, when slave_en rises.
- QUAL_DONE: qualify to locked.
- OUT_OF_WINDOW: locked to fallback.
- SYNC_LOST: locked to fallback.
- GO_MASTER: any state to master, when slave_en falls.

Top module: `swclk_sync_gen`

## Requirements
- R1: After reset, mode is 00 (master) and sync_oe is 1.
- R2: In master mode the distance between cycle_start pulses is round(125000 / f) system ticks. Here f in kHz is 200 + 50·code for codes 0 to 20, and 1200 + 100·(code − 20) for codes 21 to 26. Codes above 26 act as code 26.
- R3: cycle_start is a one-tick pulse. In master mode sync_out rises in the tick that carries cycle_start and stays high for round(0.45·P) ticks, where P is the period from R2.
- R4: slave_en high takes the block from master to qualify (mode 01). In any mode other than master, sync_oe and sync_out are 0.
- R5: In qualify, mode becomes 10 (locked) on the sync rising edge that completes the 64th consecutive valid period. The first rising edge after entry only opens the first period.
- R6: A sync high pulse shorter than 17 ticks, or a low pulse shorter than 19 ticks, makes the period invalid and restarts the count of R5. Widths of exactly 17 high and 19 low are valid.
- R7: Locked with phase_sel = 0, cycle_start is sampled high in tick 25 after the tick in which sync_in rises (200 ns at 8 ns per tick, input synchronizer included).
- R8: Locked with phase_sel = 1, cycle_start is sampled high 25 ticks after sync_in falls, and not after the rise.
- R9: Locked, a measured sync period between ceil(0.8·P) and floor(1.2·P) ticks inclusive keeps mode 10. A period outside that window sets mode 11 (fallback).
- R10: Locked, no sync rising edge for more than floor(1.2·P) ticks sets mode 11.
- R11: Fallback holds while slave_en stays high, with cycle_start paced by the internal period P. slave_en low returns the block to master (mode 00, sync_oe 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (125 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_code | input | 5 | Switching frequency code, registered inside |
| slave_en | input | 1 | 1 selects slave operation, 0 selects master |
| phase_sel | input | 1 | 0 lags the sync rising edge, 1 lags the falling edge |
| sync_in | input | 1 | External sync line, asynchronous |
| sync_out | output | 1 | Sync line drive value in master mode |
| sync_oe | output | 1 | Drive enable for the sync line |
| cycle_start | output | 1 | One-tick pulse at each switching cycle start |
| mode | output | 2 | 00 master, 01 qualify, 10 locked, 11 fallback |

## Verification
The master path is swept over every frequency code plus one code beyond the last. Period and high time are checked against arithmetic formulas, which separates the fine-step and coarse-step ranges from the clamp. Slave qualification is driven with clean trains at the minimum legal widths, and with trains that carry a single pulse one tick too short, either high or low. These runs show the exact edge count at which lock is reached and prove that a bad width restarts the count. Once locked, the lag is measured against both edge selections, and periods exactly at and one tick beyond the window limits are applied. A silent line tells the window fallback apart from the loss-of-signal fallback, and both are shown to hold until slave_en is removed.

// File: rtl/swclk_pkg.sv
package swclk_pkg;

    typedef enum logic [1:0] {
        MODE_MASTER   = 2'b00,
        MODE_QUALIFY  = 2'b01,
        MODE_LOCKED   = 2'b10,
        MODE_FALLBACK = 2'b11
    } swclk_mode_e;

    // Frequency in kHz for a code: fine steps up to the knee, coarse above it.
    function automatic int unsigned code_khz(
        input int unsigned code,
        input int unsigned f_min,
        input int unsigned f_fine,
        input int unsigned f_knee,
        input int unsigned f_coarse
    );
        int unsigned fine_codes;
        fine_codes = (f_knee - f_min) / f_fine;
        if (code <= fine_codes)
            return f_min + code * f_fine;
        return f_knee + (code - fine_codes) * f_coarse;
    endfunction

endpackage

// File: rtl/swclk_period_rom.sv
module swclk_period_rom #(
    parameter int unsigned SYS_KHZ      = 125000,
    parameter int unsigned F_MIN_KHZ    = 200,
    parameter int unsigned F_FINE_KHZ   = 50,
    parameter int unsigned F_KNEE_KHZ   = 1200,
    parameter int unsigned F_COARSE_KHZ = 100,
    parameter int unsigned N_CODES      = 27,
    parameter int unsigned DUTY_PCT     = 45,
    parameter int unsigned CODE_W       = 5,
    parameter int unsigned CNT_W        = 12
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  hi_ticks,
    output logic [CNT_W-1:0]  win_lo,
    output logic [CNT_W-1:0]  win_hi
);
    localparam int unsigned N_ROWS = 2 ** CODE_W;

    logic [CNT_W-1:0] per_tab [N_ROWS];
    logic [CNT_W-1:0] hi_tab  [N_ROWS];
    logic [CNT_W-1:0] lo_tab  [N_ROWS];
    logic [CNT_W-1:0] up_tab  [N_ROWS];

    // Rows past the last code repeat the last code (clamp).
    for (genvar i = 0; i < N_ROWS; i++) begin : g_row
        localparam int unsigned IDX = (i < N_CODES) ? i : N_CODES - 1;
        localparam int unsigned F   = swclk_pkg::code_khz(IDX, F_MIN_KHZ, F_FINE_KHZ,
                                                          F_KNEE_KHZ, F_COARSE_KHZ);
        localparam int unsigned P   = (SYS_KHZ + F / 2) / F;
        assign per_tab[i] = CNT_W'(P);
        assign hi_tab[i]  = CNT_W'((P * DUTY_PCT + 50) / 100);
        assign lo_tab[i]  = CNT_W'((P * 4 + 4) / 5);
        assign up_tab[i]  = CNT_W'((P * 6) / 5);
    end

    assign period   = per_tab[code];
    assign hi_ticks = hi_tab[code];
    assign win_lo   = lo_tab[code];
    assign win_hi   = up_tab[code];
endmodule

// File: rtl/swclk_sync_meas.sv
module swclk_sync_meas #(
    parameter int unsigned CNT_W        = 12,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned MIN_HI_TICKS = 17,
    parameter int unsigned MIN_LO_TICKS = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] win_hi,
    output logic             rise,
    output logic             fall,
    output logic             meas_stb,
    output logic             meas_ok,
    output logic [CNT_W-1:0] meas_period,
    output logic             lost_stb
);
    logic [SYNC_STAGES:0] sh_q;
    logic [CNT_W-1:0]     run_cnt;
    logic [CNT_W-1:0]     per_cnt;
    logic                 hi_ok;
    logic                 armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], sync_in};
    end

    assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    assign fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt     <= '0;
            per_cnt     <= '0;
            hi_ok       <= 1'b0;
            armed       <= 1'b0;
            meas_stb    <= 1'b0;
            meas_ok     <= 1'b0;
            meas_period <= '0;
            lost_stb    <= 1'b0;
        end else begin
            meas_stb <= 1'b0;
            lost_stb <= 1'b0;
            if (rise || fall)        run_cnt <= CNT_W'(1);
            else if (run_cnt != '1)  run_cnt <= run_cnt + 1'b1;
            if (rise)                per_cnt <= CNT_W'(1);
            else if (per_cnt != '1)  per_cnt <= per_cnt + 1'b1;
            if (fall)
                hi_ok <= (run_cnt >= CNT_W'(MIN_HI_TICKS));
            if (rise) begin
                meas_stb    <= 1'b1;
                meas_ok     <= armed && hi_ok && (run_cnt >= CNT_W'(MIN_LO_TICKS));
                meas_period <= per_cnt;
                armed       <= 1'b1;
            end else if (armed && (per_cnt > win_hi)) begin
                lost_stb <= 1'b1;
                armed    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/swclk_osc.sv
module swclk_osc #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] hi_ticks,
    input  logic             align,
    output logic             wrap,
    output logic             hi_phase
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt <= '0;
        else if (align)                     cnt <= CNT_W'(1);
        else if (cnt >= period - 1'b1)      cnt <= '0;
        else                                cnt <= cnt + 1'b1;
    end

    assign wrap     = (cnt == '0);
    assign hi_phase = (cnt < hi_ticks);
endmodule

// File: rtl/swclk_sync_gen.sv
module swclk_sync_gen
    import swclk_pkg::*;
#(
    parameter int unsigned SYS_KHZ      = 125000,
    parameter int unsigned F_MIN_KHZ    = 200,
    parameter int unsigned F_FINE_KHZ   = 50,
    parameter int unsigned F_KNEE_KHZ   = 1200,
    parameter int unsigned F_COARSE_KHZ = 100,
    parameter int unsigned F_MAX_KHZ    = 1800,
    parameter int unsigned DUTY_PCT     = 45,
    parameter int unsigned CNT_W        = 12,
    parameter int unsigned QUAL_CYCLES  = 64,
    parameter int unsigned LAG_TICKS    = 25,
    parameter int unsigned MIN_HI_TICKS = 17,
    parameter int unsigned MIN_LO_TICKS = 19,
    parameter int unsigned SYNC_STAGES  = 2,
    localparam int unsigned N_CODES     = (F_KNEE_KHZ - F_MIN_KHZ) / F_FINE_KHZ
                                        + (F_MAX_KHZ - F_KNEE_KHZ) / F_COARSE_KHZ + 1,
    localparam int unsigned CODE_W      = $clog2(N_CODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] freq_code,
    input  logic              slave_en,
    input  logic              phase_sel,
    input  logic              sync_in,
    output logic              sync_out,
    output logic              sync_oe,
    output logic              cycle_start,
    output logic [1:0]        mode
);
    localparam int unsigned QUAL_W   = $clog2(QUAL_CYCLES + 1);
    localparam int unsigned LAG_W    = $clog2(LAG_TICKS + 1);
    localparam int unsigned LAG_LOAD = LAG_TICKS - SYNC_STAGES - 1;

    swclk_mode_e      state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0] period, hi_ticks, win_lo, win_hi, meas_period;
    logic             rise, fall, meas_stb, meas_ok, lost_stb;
    logic             wrap, hi_phase, in_window, qual_done;
    logic [QUAL_W-1:0] qual_cnt;
    logic [LAG_W-1:0] lag_cnt;
    logic             lag_busy, lag_fire, lag_trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= freq_code;
    end

    swclk_period_rom #(
        .SYS_KHZ(SYS_KHZ), .F_MIN_KHZ(F_MIN_KHZ), .F_FINE_KHZ(F_FINE_KHZ),
        .F_KNEE_KHZ(F_KNEE_KHZ), .F_COARSE_KHZ(F_COARSE_KHZ), .N_CODES(N_CODES),
        .DUTY_PCT(DUTY_PCT), .CODE_W(CODE_W), .CNT_W(CNT_W)
    ) rom_i (
        .code(code_q), .period(period), .hi_ticks(hi_ticks),
        .win_lo(win_lo), .win_hi(win_hi)
    );

    swclk_sync_meas #(
        .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES),
        .MIN_HI_TICKS(MIN_HI_TICKS), .MIN_LO_TICKS(MIN_LO_TICKS)
    ) meas_i (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .win_hi(win_hi),
        .rise(rise), .fall(fall), .meas_stb(meas_stb), .meas_ok(meas_ok),
        .meas_period(meas_period), .lost_stb(lost_stb)
    );

    swclk_osc #(.CNT_W(CNT_W)) osc_i (
        .clk(clk), .rst_n(rst_n), .period(period), .hi_ticks(hi_ticks),
        .align(lag_fire && (state_q == MODE_LOCKED)),
        .wrap(wrap), .hi_phase(hi_phase)
    );

    // Fixed lag from the selected sync edge; synchronizer delay is included.
    assign lag_trig = phase_sel ? fall : rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lag_cnt  <= '0;
            lag_busy <= 1'b0;
        end else if (lag_trig) begin
            lag_cnt  <= LAG_W'(LAG_LOAD);
            lag_busy <= 1'b1;
        end else if (lag_busy) begin
            if (lag_cnt == '0) lag_busy <= 1'b0;
            else               lag_cnt  <= lag_cnt - 1'b1;
        end
    end

    assign lag_fire  = lag_busy && (lag_cnt == '0);
    assign in_window = (meas_period >= win_lo) && (meas_period <= win_hi);
    assign qual_done = meas_stb && meas_ok && (qual_cnt == QUAL_W'(QUAL_CYCLES - 1));

    // Count of consecutive valid periods while qualifying.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    qual_cnt <= '0;
        else if (state_q != MODE_QUALIFY)              qual_cnt <= '0;
        else if (lost_stb || (meas_stb && !meas_ok))   qual_cnt <= '0;
        else if (meas_stb)                             qual_cnt <= qual_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_MASTER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_MASTER:   if (slave_en) state_d = MODE_QUALIFY;          // GO_SLAVE
            MODE_QUALIFY:  if (!slave_en) state_d = MODE_MASTER;          // GO_MASTER
                           else if (qual_done) state_d = MODE_LOCKED;     // QUAL_DONE
            MODE_LOCKED:   if (!slave_en) state_d = MODE_MASTER;          // GO_MASTER
                           else if (lost_stb) state_d = MODE_FALLBACK;    // SYNC_LOST
                           else if (meas_stb && !in_window)
                               state_d = MODE_FALLBACK;                   // OUT_OF_WINDOW
            MODE_FALLBACK: if (!slave_en) state_d = MODE_MASTER;          // GO_MASTER
            default:       state_d = MODE_MASTER;
        endcase
    end

    always_comb begin
        sync_oe     = 1'b0;
        sync_out    = 1'b0;
        cycle_start = wrap;
        unique case (state_q)
            MODE_MASTER: begin
                sync_oe  = 1'b1;
                sync_out = hi_phase;
            end
            MODE_LOCKED:   cycle_start = lag_fire;
            MODE_QUALIFY,
            MODE_FALLBACK: cycle_start = wrap;
            default:       cycle_start = wrap;
        endcase
    end

    assign mode = state_q;
endmodule

// File: rtl/swclk_sync_gen_chk.sv
module swclk_sync_gen_chk
    import swclk_pkg::*;
#(
    parameter int unsigned CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_en,
    input logic [1:0]        mode,
    input logic              sync_out,
    input logic              sync_oe,
    input logic              cycle_start,
    input logic [CODE_W-1:0] code_q
);
    AST_LOCK_ONLY_FROM_QUALIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOCKED && $past(mode) != MODE_LOCKED) |-> $past(mode) == MODE_QUALIFY); // R5

    AST_MASTER_EXITS_TO_QUALIFY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_MASTER && mode != MODE_MASTER) |-> mode == MODE_QUALIFY); // R4

    AST_SLAVE_LINE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_MASTER) |-> (!sync_oe && !sync_out)); // R4

    AST_FALLBACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FALLBACK && slave_en) |=> mode == MODE_FALLBACK); // R11

    AST_START_SINGLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start); // R3

    AST_SYNC_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MASTER && $past(mode) == MODE_MASTER && $stable(code_q) && $rose(sync_out))
        |-> cycle_start); // R3
endmodule

bind swclk_sync_gen swclk_sync_gen_chk #(.CODE_W(CODE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .mode(mode),
    .sync_out(sync_out), .sync_oe(sync_oe), .cycle_start(cycle_start),
    .code_q(code_q)
);

// File: tb/swclk_sync_gen_tb_top.sv
module swclk_sync_gen_tb_top;
    localparam int SYS_KHZ = 125000;
    localparam int LAG     = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] freq_code = 5'd8;
    logic       slave_en = 1'b0;
    logic       phase_sel = 1'b0;
    logic       sync_in = 1'b0;
    logic       sync_out, sync_oe, cycle_start;
    logic [1:0] mode;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    swclk_sync_gen dut_i (
        .clk(clk), .rst_n(rst_n), .freq_code(freq_code), .slave_en(slave_en),
        .phase_sel(phase_sel), .sync_in(sync_in), .sync_out(sync_out),
        .sync_oe(sync_oe), .cycle_start(cycle_start), .mode(mode)
    );

    function automatic int khz(input int code);
        int c;
        c = (code > 26) ? 26 : code;
        return (c <= 20) ? 200 + 50 * c : 1200 + 100 * (c - 20);
    endfunction
    function automatic int per_of(input int code);
        return (SYS_KHZ + khz(code) / 2) / khz(code);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_start();
        for (int i = 0; i < 2000; i++) begin
            tick();
            if (cycle_start) return;
        end
    endtask

    // Measure the cycle starting at the current sample (cycle_start high).
    task automatic measure_cycle(output int per, output int hi, output int al);
        per = 0;
        hi  = 0;
        al  = int'(sync_out);
        for (int i = 0; i < 2000; i++) begin
            if (sync_out) hi++;
            tick();
            per++;
            if (cycle_start) return;
        end
    endtask

    // One sync period: high for hi ticks, then low. Returns first start tick.
    task automatic drive_cycle(input int per, input int hi, output int first);
        first = 0;
        sync_in = 1'b1;
        for (int k = 1; k <= per; k++) begin
            tick();
            if (k == hi) sync_in = 1'b0;
            if (cycle_start && first == 0) first = k;
        end
    endtask

    task automatic run_cycles(input int n, input int per, input int hi);
        int f;
        for (int i = 0; i < n; i++) drive_cycle(per, hi, f);
    endtask

    task automatic bad_width_run(input string req, input int bper, input int bhi);
        slave_en = 1'b0;
        tick();
        tick();
        slave_en = 1'b1;
        tick();
        run_cycles(40, 208, 100);
        run_cycles(1, bper, bhi);
        run_cycles(64, 208, 100);
        check(req, int'(mode), 1);
        run_cycles(1, 208, 100);
        check(req, int'(mode), 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int p, h, a, f;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 mode", int'(mode), 0);
        check("R1 sync_oe", int'(sync_oe), 1);
        rst_n = 1'b1;
        tick();

        // R2/R3: sweep of every code, plus one beyond the last
        for (int c = 0; c <= 27; c++) begin
            int code;
            code = (c == 27) ? 31 : c;
            freq_code = 5'(code);
            wait_start();
            wait_start();
            measure_cycle(p, h, a);
            check($sformatf("R2 period code %0d", code), p, per_of(code));
            check($sformatf("R3 high code %0d", code), h, (per_of(code) * 45 + 50) / 100);
            check($sformatf("R3 align code %0d", code), a, 1);
        end

        // R4/R5: qualification with minimum high width (R6 boundary)
        freq_code = 5'd8;
        tick();
        slave_en = 1'b1;
        tick();
        tick();
        check("R4 mode", int'(mode), 1);
        check("R4 sync_oe", int'(sync_oe), 0);
        run_cycles(64, 208, 17);
        check("R5 before lock", int'(mode), 1);
        check("R4 sync_out", int'(sync_out), 0);
        run_cycles(1, 208, 17);
        check("R5 locked", int'(mode), 2);

        // R7: in-phase lag
        drive_cycle(208, 100, f);
        check("R7 lag", f, LAG);
        drive_cycle(208, 100, f);
        check("R7 lag again", f, LAG);

        // R8: out-of-phase lag
        phase_sel = 1'b1;
        drive_cycle(208, 100, f);
        drive_cycle(208, 100, f);
        check("R8 lag", f, 100 + LAG);
        phase_sel = 1'b0;
        drive_cycle(208, 100, f);

        // R9: window limits for P = 208: [167, 249]
        drive_cycle(167, 80, f);
        drive_cycle(249, 100, f);
        drive_cycle(208, 100, f);
        check("R9 in window", int'(mode), 2);
        drive_cycle(166, 80, f);
        drive_cycle(208, 100, f);
        check("R9 out of window", int'(mode), 3);

        // R11: fallback paced by internal period, sticky, exit to master
        wait_start();
        wait_start();
        measure_cycle(p, h, a);
        check("R11 fallback period", p, 208);
        run_cycles(3, 208, 100);
        check("R11 sticky", int'(mode), 3);
        slave_en = 1'b0;
        tick();
        tick();
        check("R11 master mode", int'(mode), 0);
        check("R11 sync_oe", int'(sync_oe), 1);

        // R6 low boundary, then R10 loss of sync
        slave_en = 1'b1;
        tick();
        run_cycles(65, 208, 189);
        check("R6 low 19 accepted", int'(mode), 2);
        repeat (100) tick();
        check("R10 lost", int'(mode), 3);

        // R6: one short high pulse, then one short low pulse
        bad_width_run("R6 short high", 208, 16);
        bad_width_run("R6 short low", 207, 189);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule